// File: doc/BRIEF.md
# Return Data Bus Arbiter

This block shares one return data bus between many finished bank accesses and the memory controller. Each finished access raises a request with its transfer size and a small tag. A request that finds the bus idle starts its transfer at once. A request that finds the bus busy waits in an in-order queue of eight entries. It starts in the cycle right after the transfer ahead of it ends, so the bus never stands idle while work is waiting.

The time a transfer holds the bus is derived from its size. A transfer no wider than the bus takes one beat. A wider transfer takes one beat for every bus width of data it carries, and any partial remainder is dropped. Beat length and bus width (given as a power-of-two shift) come from configuration inputs, which are captured when a transfer starts. For each transfer the block gives the controller two pulses. One is a data-ready pulse. The other is a completion pulse, and both carry the transfer's tag. With the critical-word option on, the data-ready pulse comes at the end of the first beat. With the option off, it comes together with the completion pulse. A request that arrives when the queue is full and cannot drain in that cycle is dropped, and a sticky overflow flag records this.

Top module: `rbus_arbiter`

## Requirements
- R1: After reset, busBusy, dataReady, donePulse and overflow are all 0.
- R2: A request sampled while the bus is idle starts its transfer at that clock edge. busBusy is 1 from the next cycle, and that cycle is cycle 1 of the transfer.
- R3: With reqSize no greater than 2^cfgWidthShift, the transfer lasts B cycles, where B is cfgBeatCycles (a value of 0 counts as 1). donePulse is 1 in cycle B of the transfer.
- R4: With reqSize greater than 2^cfgWidthShift, the transfer lasts B*(reqSize >> cfgWidthShift) cycles, and donePulse is 1 in the last of them.
- R5: With cfgCritWord = 0 at the start, dataReady is 1 in exactly the same cycle as donePulse.
- R6: With cfgCritWord = 1 at the start, dataReady is 1 in cycle B of the transfer, which is the end of the first beat. donePulse still comes in the last cycle.
- R7: Requests that arrive while the bus is busy are served in arrival order. Each queued transfer has its cycle 1 in the cycle right after the donePulse cycle of the transfer before it.
- R8: If the queue is empty at the donePulse cycle, busBusy is 0 in the next cycle. The exception is a request sampled at that same edge, which starts at once.
- R9: The queue holds 8 requests. A request that arrives while the bus is busy, is not in its last cycle and has a full queue is dropped, and it never yields a pulse. overflow then becomes 1 and stays 1 until reset.
- R10: xferId shows the reqId of the transfer in progress during its dataReady and donePulse cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A finished access requests the bus this cycle |
| reqSize | input | 8 | Transfer size in bytes |
| reqId | input | 4 | Tag of the requesting access |
| cfgWidthShift | input | 3 | Bus width as log2 of bytes |
| cfgBeatCycles | input | 4 | Cycles per bus beat (0 counts as 1) |
| cfgCritWord | input | 1 | Signal data-ready after the first beat |
| busBusy | output | 1 | A transfer holds the bus |
| dataReady | output | 1 | One-cycle data-ready pulse |
| donePulse | output | 1 | One-cycle completion pulse |
| xferId | output | 4 | Tag of the current transfer |
| overflow | output | 1 | Sticky flag: a request was dropped |

## Verification
A bad cycle counter or a bad latched duration moves donePulse by a whole number of cycles. The bench shows this in the first transfer, because it logs the exact cycle of every pulse. A broken queue pointer or a lost pop shows up as a wrong tag or a missing completion in the first chain of queued requests. An idle flag that fails to clear, or a queue that is not empty when the bus goes idle, leaves busBusy stuck or starts a phantom transfer within one cycle of the last completion.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  typedef struct packed {
    logic load;       // start a transfer at this edge
    logic fromQueue;  // its request comes from the queue head
    logic push;       // store the incoming request
    logic pop;        // remove the queue head
    logic halt;       // bus goes idle
  } rbusStrobes_t;
endpackage

// File: rtl/rbus_fifo.sv
module rbus_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] level;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (level == '0);
  assign full     = (level == CNT_W'(DEPTH));
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= wrData;
        wrPtr        <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/rbus_ctrl.sv
module rbus_ctrl
  import rbus_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         lastCycle,
  input  logic         qEmpty,
  input  logic         qFull,
  output rbusStrobes_t strobes,
  output logic         active,
  output logic         overflow
);
  logic freeNow;
  logic dropReq;

  assign freeNow = !active || lastCycle;

  always_comb begin
    strobes = '0;
    dropReq = 1'b0;
    if (freeNow) begin
      if (!qEmpty) begin
        strobes.load      = 1'b1;
        strobes.fromQueue = 1'b1;
        strobes.pop       = 1'b1;
        strobes.push      = reqValid;
      end else if (reqValid) begin
        strobes.load = 1'b1;
      end else if (active) begin
        strobes.halt = 1'b1;
      end
    end else if (reqValid) begin
      strobes.push = !qFull;
      dropReq      = qFull;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strobes.load)      active <= 1'b1;
      else if (strobes.halt) active <= 1'b0;
      if (dropReq) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rbus_dp.sv
module rbus_dp
  import rbus_pkg::*;
#(
  parameter int SIZE_W  = 8,
  parameter int ID_W    = 4,
  parameter int SHIFT_W = 3,
  parameter int BEAT_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  rbusStrobes_t       strobes,
  input  logic               active,
  input  logic [SIZE_W-1:0]  reqSize,
  input  logic [ID_W-1:0]    reqId,
  input  logic [SIZE_W-1:0]  headSize,
  input  logic [ID_W-1:0]    headId,
  input  logic [SHIFT_W-1:0] cfgWidthShift,
  input  logic [BEAT_W-1:0]  cfgBeatCycles,
  input  logic               cfgCritWord,
  output logic               lastCycle,
  output logic               dataReady,
  output logic               donePulse,
  output logic [ID_W-1:0]    xferId
);
  localparam int DUR_W = SIZE_W + BEAT_W;

  logic [SIZE_W-1:0] srcSize;
  logic [ID_W-1:0]   srcId;
  logic [BEAT_W-1:0] beatEff;
  logic [DUR_W-1:0]  durNext;
  logic [DUR_W-1:0]  durQ, beatQ, cnt;
  logic              critQ;
  int unsigned       sizeU, busWidth;

  assign srcSize = strobes.fromQueue ? headSize : reqSize;
  assign srcId   = strobes.fromQueue ? headId   : reqId;
  assign beatEff = (cfgBeatCycles == '0) ? BEAT_W'(1) : cfgBeatCycles;

  always_comb begin
    sizeU    = 32'(srcSize);
    busWidth = 32'd1 << cfgWidthShift;
    if (sizeU <= busWidth) durNext = DUR_W'(beatEff);
    else durNext = DUR_W'(beatEff) * DUR_W'(srcSize >> cfgWidthShift);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      durQ   <= DUR_W'(1);
      beatQ  <= DUR_W'(1);
      critQ  <= 1'b0;
      cnt    <= '0;
      xferId <= '0;
    end else if (strobes.load) begin
      durQ   <= durNext;
      beatQ  <= DUR_W'(beatEff);
      critQ  <= cfgCritWord;
      cnt    <= DUR_W'(1);
      xferId <= srcId;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lastCycle = active && (cnt == durQ);
  assign donePulse = lastCycle;
  assign dataReady = active && (cnt == (critQ ? beatQ : durQ));
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
  import rbus_pkg::*;
#(
  parameter int SIZE_W  = 8,
  parameter int ID_W    = 4,
  parameter int SHIFT_W = 3,
  parameter int BEAT_W  = 4,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [SIZE_W-1:0]  reqSize,
  input  logic [ID_W-1:0]    reqId,
  input  logic [SHIFT_W-1:0] cfgWidthShift,
  input  logic [BEAT_W-1:0]  cfgBeatCycles,
  input  logic               cfgCritWord,
  output logic               busBusy,
  output logic               dataReady,
  output logic               donePulse,
  output logic [ID_W-1:0]    xferId,
  output logic               overflow
);
  localparam int ENTRY_W = SIZE_W + ID_W;

  rbusStrobes_t      strobes;
  logic              lastCycle, qEmpty, qFull;
  logic [ENTRY_W-1:0] headData;

  rbus_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) queue (
    .clk(clk), .rstN(rstN), .push(strobes.push), .pop(strobes.pop),
    .wrData({reqSize, reqId}), .headData(headData),
    .empty(qEmpty), .full(qFull)
  );

  rbus_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lastCycle(lastCycle),
    .qEmpty(qEmpty), .qFull(qFull), .strobes(strobes),
    .active(busBusy), .overflow(overflow)
  );

  rbus_dp #(.SIZE_W(SIZE_W), .ID_W(ID_W), .SHIFT_W(SHIFT_W), .BEAT_W(BEAT_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .active(busBusy),
    .reqSize(reqSize), .reqId(reqId),
    .headSize(headData[ENTRY_W-1:ID_W]), .headId(headData[ID_W-1:0]),
    .cfgWidthShift(cfgWidthShift), .cfgBeatCycles(cfgBeatCycles),
    .cfgCritWord(cfgCritWord), .lastCycle(lastCycle),
    .dataReady(dataReady), .donePulse(donePulse), .xferId(xferId)
  );
endmodule

// File: rtl/rbus_arbiter_chk.sv
module rbus_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic busBusy,
  input logic dataReady,
  input logic donePulse,
  input logic overflow,
  input logic qEmpty
);
  assert_pulse_needs_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady || donePulse) |-> busBusy);

  assert_idle_queue_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> qEmpty);

  assert_chain_next_R7: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && !qEmpty) |=> busBusy);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_overflow_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> busBusy);
endmodule

bind rbus_arbiter rbus_arbiter_chk chk (
  .clk(clk), .rstN(rstN), .busBusy(busBusy), .dataReady(dataReady),
  .donePulse(donePulse), .overflow(overflow), .qEmpty(qEmpty)
);

// File: tb/rbus_arbiter_test.sv
module rbus_arbiter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqSize = '0;
  logic [3:0] reqId = '0;
  logic [2:0] cfgWidthShift = '0;
  logic [3:0] cfgBeatCycles = 4'd1;
  logic       cfgCritWord = 1'b0;
  logic       busBusy, dataReady, donePulse, overflow;
  logic [3:0] xferId;

  int cyc = 0;
  int nRun = 0, nFail = 0;
  int nDone = 0, nReady = 0;
  int doneCyc [16];
  int doneTag [16];
  int readyCyc [16];
  int readyTag [16];

  rbus_arbiter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
    .reqId(reqId), .cfgWidthShift(cfgWidthShift), .cfgBeatCycles(cfgBeatCycles),
    .cfgCritWord(cfgCritWord), .busBusy(busBusy), .dataReady(dataReady),
    .donePulse(donePulse), .xferId(xferId), .overflow(overflow)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rstN) begin
    if (donePulse && nDone < 16) begin
      doneCyc[nDone] = cyc; doneTag[nDone] = int'(xferId); nDone++;
    end
    if (dataReady && nReady < 16) begin
      readyCyc[nReady] = cyc; readyTag[nReady] = int'(xferId); nReady++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    nDone = 0; nReady = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; reqValid = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic setCfg(input int sh, input int beat, input bit crit);
    cfgWidthShift = 3'(sh); cfgBeatCycles = 4'(beat); cfgCritWord = crit;
  endtask

  // Drive one request at the current negedge; returns its cycle number.
  task automatic issue(input int size, input int id, output int c);
    c = cyc; reqValid = 1'b1; reqSize = 8'(size); reqId = 4'(id);
    @(posedge clk); @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && busBusy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(busBusy == 0 && dataReady == 0 && donePulse == 0 && overflow == 0,
          "R1 outputs after reset", {busBusy, dataReady, donePulse, overflow}, 0);
  endtask

  task automatic oneXfer(input int size, input int id, input int dur, input int rdy,
                         input string tag);
    int c;
    clearLog(); issue(size, id, c);
    check(busBusy == 1, "R2 busy in cycle 1", busBusy, 1);
    waitIdle();
    check(nDone == 1 && doneCyc[0] == c + dur, {tag, " done cycle"}, doneCyc[0] - c, dur);
    check(nReady == 1 && readyCyc[0] == c + rdy, {tag, " ready cycle"}, readyCyc[0] - c, rdy);
    check(doneTag[0] == id && readyTag[0] == id, "R10 tag on pulses", doneTag[0], id);
  endtask

  task automatic t_small();
    setCfg(2, 5, 0);
    oneXfer(3, 4'h3, 5, 5, "R3 R5 size3");
    oneXfer(4, 4'h4, 5, 5, "R3 size at width");
    setCfg(0, 0, 0);
    oneXfer(1, 4'h1, 1, 1, "R3 beat0 as 1");
  endtask

  task automatic t_large();
    setCfg(2, 3, 0);
    oneXfer(9, 4'h9, 6, 6, "R4 size9");
    setCfg(3, 2, 0);
    oneXfer(255, 4'hF, 62, 62, "R4 size255");
  endtask

  task automatic t_crit();
    setCfg(2, 3, 1);
    oneXfer(16, 4'hC, 12, 3, "R6 crit");
  endtask

  task automatic t_queue();
    int c0, c1, c2;
    setCfg(0, 2, 0); clearLog();
    issue(3, 4'hA, c0); issue(1, 4'hB, c1); issue(2, 4'h5, c2);
    waitIdle();
    check(nDone == 3, "R7 three completions", nDone, 3);
    check(doneCyc[0] == c0 + 6, "R7 first done", doneCyc[0] - c0, 6);
    check(doneCyc[1] == c0 + 8, "R7 second back to back", doneCyc[1] - c0, 8);
    check(doneCyc[2] == c0 + 12, "R7 third back to back", doneCyc[2] - c0, 12);
    check(doneTag[0] == 4'hA && doneTag[1] == 4'hB && doneTag[2] == 4'h5,
          "R7 R10 arrival order", doneTag[1], 4'hB);
  endtask

  task automatic t_bypass();
    int c0, c1;
    setCfg(0, 2, 0); clearLog();
    issue(1, 4'h2, c0);
    while (cyc < c0 + 2) @(negedge clk);
    check(donePulse == 1, "R3 done before bypass", donePulse, 1);
    issue(1, 4'h6, c1);
    check(busBusy == 1, "R8 same-edge request starts", busBusy, 1);
    while (cyc < c1 + 2) @(negedge clk);
    check(donePulse == 1 && xferId == 4'h6, "R8 bypass done", int'(xferId), 4'h6);
    @(negedge clk);
    check(busBusy == 0, "R8 idle after last done", busBusy, 0);
  endtask

  task automatic t_overflow();
    int c;
    setCfg(0, 4, 0); clearLog();
    for (int i = 0; i < 10; i++) issue(8, i, c);
    check(overflow == 1, "R9 overflow set", overflow, 1);
    waitIdle();
    check(nDone == 9, "R9 dropped request gives no pulse", nDone, 9);
    check(doneTag[8] == 8, "R9 last served tag", doneTag[8], 8);
    check(overflow == 1, "R9 overflow sticky", overflow, 1);
    doReset();
    check(overflow == 0, "R1 R9 reset clears overflow", overflow, 0);
  endtask

  initial begin
    doReset();
    t_reset();
    t_small();
    t_large();
    t_crit();
    t_queue();
    t_bypass();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nRun++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule